// File: doc/BRIEF.md
# Snoop-Aware Reservation and Store-Conditional Unit

This block holds the one reservation that a load-reserve leaves behind in a data-cache pipeline. Before the real address is known, it watches the staged cache index and way of the load. Once the address is known, it watches the real address. Any write made by another bus agent to the reserved cache line cancels the reservation.

A store-conditional is checked against the reservation. When the check succeeds, the store is issued as a Wishbone write. If the reservation is lost while that write is on the bus, cyc and stb drop in the same cycle and the store-conditional reports failure.

The unit sits beside the cache control logic. Tag lookup, address translation and the load data path belong to that logic. The unit sees them only as an index/way pair in load stage 0, a real address in load stage 1, and a data-returned strobe.

Top module: `resv_sc_unit`

## Requirements
- R1: While rst_n is low, and after it is released, the reservation is invalid (resv_valid=0), wb_cyc, wb_stb and sc_done are 0, and the bus machine is idle.
- R2: A load-reserve presents index/way with lr_s0_valid in cycle 0 and the real address with lr_s1_valid in cycle 1. The line address is captured at the end of cycle 1 and resv_valid stays 0. resv_valid becomes 1 on the cycle after the first lr_data_valid pulse that follows, and no earlier.
- R3: Only the first data strobe after a capture can validate the reservation. For a two-doubleword load, a second strobe that comes after the reservation was cancelled leaves resv_valid at 0.
- R4: Addresses compare at line granularity, LINE_BYTES bytes (default 64), so the low log2(LINE_BYTES) bits are ignored. A snooped write (snp_valid) to the reserved line clears resv_valid by the end of that cycle. A snooped write to another line does not.
- R5: A snooped write in cycle 0 of a load-reserve whose index and way equal the load's index and way leaves the reservation invalid after the end of cycle 1. Later data strobes do not make it valid.
- R6: A snooped write in cycle 1 of a load-reserve to the line being reserved is held for one cycle and compared in cycle 2. The reservation can then never become valid.
- R7: When a cancelling snoop and the validating data strobe fall in the same cycle, the cancel wins and resv_valid stays 0.
- R8: A store-conditional (sc_req) whose line matches a valid reservation with no cancelling snoop in that cycle raises wb_cyc, wb_stb and wb_we in the next cycle. wb_adr, wb_dat and wb_sel carry sc_addr, sc_data and sc_sel. On the first cycle in which wb_ack=1, the write completes. In the cycle after that, sc_done=1 and sc_pass=1.
- R9: A store-conditional fails without any bus cycle when the reservation is invalid or belongs to another line. In that case sc_done=1 and sc_pass=0 in the cycle after sc_req.
- R10: If a cancelling snoop arrives while the write is on the bus, wb_cyc and wb_stb are 0 in that same cycle. The next cycle shows sc_done=1 and sc_pass=0.
- R11: Every store-conditional leaves resv_valid at 0 afterwards, whether it passes or fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_s0_valid | input | 1 | Load-reserve in stage 0 |
| lr_s0_idx | input | IDX_W | Cache index of the load-reserve |
| lr_s0_way | input | WAY_W | Cache way of the load-reserve |
| lr_s1_valid | input | 1 | Load-reserve in stage 1 |
| lr_s1_addr | input | ADDR_W | Real address of the load-reserve |
| lr_data_valid | input | 1 | Load data (a doubleword) returned |
| snp_valid | input | 1 | Write by another agent observed |
| snp_idx | input | IDX_W | Cache index of the snooped write |
| snp_way | input | WAY_W | Cache way of the snooped write |
| snp_addr | input | ADDR_W | Real address of the snooped write |
| sc_req | input | 1 | Store-conditional request pulse |
| sc_addr | input | ADDR_W | Store-conditional real address |
| sc_data | input | DATA_W | Store-conditional data |
| sc_sel | input | DATA_W/8 | Store-conditional byte selects |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | ADDR_W | Wishbone address |
| wb_dat | output | DATA_W | Wishbone write data |
| wb_sel | output | DATA_W/8 | Wishbone byte selects |
| wb_ack | input | 1 | Wishbone acknowledge |
| sc_done | output | 1 | Store-conditional finished (one-cycle pulse) |
| sc_pass | output | 1 | Store-conditional succeeded, valid with sc_done |
| resv_valid | output | 1 | Reservation currently held |

## Verification
The bench targets the two windows in which the real address does not exist yet or has only just been stored.

- A snoop on the same index and way in cycle 0 must be caught. A design that ignored this snoop would grant a reservation the other agent had already broken.
- A snoop to the reserved address in cycle 1 must also be caught. A design that compared only the current snoop would miss it.

The bench also tests the three orderings around validation:

- A cancelling snoop in the same cycle as the data strobe must win. A design that gave the data strobe priority would leave a stale reservation.
- A second doubleword strobe must not revive a cancelled reservation. A design that allowed it would do exactly that.
- A snoop that arrives while the store-conditional is on the bus must end the transfer. A late abort would leave cyc up for one more cycle and could let the write complete.

Misses on a neighbouring line and offsets inside the reserved line confirm that the address compare works at line granularity.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [0:0] {
    SC_IDLE = 1'b0,
    SC_BUS  = 1'b1
  } sc_state_e;
endpackage

// File: rtl/resv_snoop_match.sv
module resv_snoop_match #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic [LINE_W-1:0] resv_line,
  output logic              hit_now,
  output logic              hit_prev
);
  logic              prev_v_q;
  logic [LINE_W-1:0] prev_line_q;
  logic              prev_v_d;
  logic [LINE_W-1:0] prev_line_d;

  always_comb begin
    prev_v_d    = snp_valid;
    prev_line_d = prev_line_q;
    if (snp_valid) prev_line_d = snp_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v_q    <= 1'b0;
      prev_line_q <= '0;
    end else begin
      prev_v_q    <= prev_v_d;
      prev_line_q <= prev_line_d;
    end
  end

  assign hit_now  = snp_valid && (snp_line == resv_line);
  assign hit_prev = prev_v_q && (prev_line_q == resv_line);
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int LINE_W = 26,
  parameter int IDX_W  = 6,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_s0_valid,
  input  logic [IDX_W-1:0]  lr_s0_idx,
  input  logic [WAY_W-1:0]  lr_s0_way,
  input  logic              lr_s1_valid,
  input  logic [LINE_W-1:0] lr_s1_line,
  input  logic              lr_data_valid,
  input  logic              snp_valid,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [WAY_W-1:0]  snp_way,
  input  logic              hit_any,
  input  logic              sc_end,
  output logic              resv_valid,
  output logic [LINE_W-1:0] resv_line,
  output logic              kill
);
  logic              valid_q, valid_d;
  logic              pend_q, pend_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              s0_kill_q, s0_kill_d;
  logic              line_en;

  // a held or pending reservation is cancelled by a line hit
  assign kill = (valid_q || pend_q) && hit_any;

  always_comb begin
    s0_kill_d = lr_s0_valid && snp_valid &&
                (snp_idx == lr_s0_idx) && (snp_way == lr_s0_way);
    line_en   = lr_s1_valid;
    line_d    = lr_s1_line;
    valid_d   = valid_q;
    pend_d    = pend_q;
    if (lr_s1_valid) begin
      valid_d = 1'b0;
      pend_d  = !s0_kill_q;
    end else if (kill || sc_end) begin
      valid_d = 1'b0;
      pend_d  = 1'b0;
    end else if (lr_data_valid && pend_q) begin
      valid_d = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      pend_q    <= 1'b0;
      line_q    <= '0;
      s0_kill_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      pend_q    <= pend_d;
      s0_kill_q <= s0_kill_d;
      if (line_en) line_q <= line_d;
    end
  end

  assign resv_valid = valid_q;
  assign resv_line  = line_q;

  a_r4_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kill && !lr_s1_valid |=> !resv_valid);
  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resv_valid) |-> $past(lr_data_valid));
  a_r7_no_set_on_kill: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any && !lr_s1_valid |=> !resv_valid);
endmodule

// File: rtl/sc_bus_fsm.sv
module sc_bus_fsm
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LINE_W = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sc_req,
  input  logic [ADDR_W-1:0]   sc_addr,
  input  logic [DATA_W-1:0]   sc_data,
  input  logic [DATA_W/8-1:0] sc_sel,
  input  logic                resv_valid,
  input  logic [LINE_W-1:0]   resv_line,
  input  logic                kill,
  input  logic                wb_ack,
  output logic                wb_cyc,
  output logic                wb_stb,
  output logic                wb_we,
  output logic [ADDR_W-1:0]   wb_adr,
  output logic [DATA_W-1:0]   wb_dat,
  output logic [DATA_W/8-1:0] wb_sel,
  output logic                sc_done,
  output logic                sc_pass,
  output logic                sc_end
);
  localparam int OFF_W = ADDR_W - LINE_W;

  sc_state_e           state_q, state_d;
  logic [ADDR_W-1:0]   adr_q;
  logic [DATA_W-1:0]   dat_q;
  logic [DATA_W/8-1:0] sel_q;
  logic                req_en;
  logic                done_d, pass_d, done_q, pass_q;
  logic                line_ok;

  assign line_ok = (sc_addr[ADDR_W-1:OFF_W] == resv_line);

  always_comb begin
    state_d = state_q;
    req_en  = 1'b0;
    done_d  = 1'b0;
    pass_d  = 1'b0;
    unique case (state_q)
      SC_IDLE: begin
        if (sc_req) begin
          if (resv_valid && !kill && line_ok) begin
            state_d = SC_BUS;
            req_en  = 1'b1;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      SC_BUS: begin
        if (kill) begin
          state_d = SC_IDLE;
          done_d  = 1'b1;
        end else if (wb_ack) begin
          state_d = SC_IDLE;
          done_d  = 1'b1;
          pass_d  = 1'b1;
        end
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      adr_q   <= '0;
      dat_q   <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      if (req_en) begin
        adr_q <= sc_addr;
        dat_q <= sc_data;
        sel_q <= sc_sel;
      end
    end
  end

  // losing the reservation drops the strobe in the very same cycle
  assign wb_cyc  = (state_q == SC_BUS) && !kill;
  assign wb_stb  = wb_cyc;
  assign wb_we   = wb_cyc;
  assign wb_adr  = adr_q;
  assign wb_dat  = dat_q;
  assign wb_sel  = sel_q;
  assign sc_done = done_q;
  assign sc_pass = pass_q;
  assign sc_end  = done_d;

  a_r8_pass_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done && sc_pass |-> $past(wb_ack && wb_cyc));
  a_r8_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && !wb_ack |=> state_q == SC_BUS);
  a_r10_abort_fails: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wb_cyc) && !$past(wb_ack) |=> sc_done && !sc_pass);
  a_r11_resv_gone: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> !resv_valid);
endmodule

// File: rtl/resv_sc_unit.sv
module resv_sc_unit #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int IDX_W      = 6,
  parameter int WAY_W      = 2,
  parameter int LINE_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lr_s0_valid,
  input  logic [IDX_W-1:0]    lr_s0_idx,
  input  logic [WAY_W-1:0]    lr_s0_way,
  input  logic                lr_s1_valid,
  input  logic [ADDR_W-1:0]   lr_s1_addr,
  input  logic                lr_data_valid,
  input  logic                snp_valid,
  input  logic [IDX_W-1:0]    snp_idx,
  input  logic [WAY_W-1:0]    snp_way,
  input  logic [ADDR_W-1:0]   snp_addr,
  input  logic                sc_req,
  input  logic [ADDR_W-1:0]   sc_addr,
  input  logic [DATA_W-1:0]   sc_data,
  input  logic [DATA_W/8-1:0] sc_sel,
  output logic                wb_cyc,
  output logic                wb_stb,
  output logic                wb_we,
  output logic [ADDR_W-1:0]   wb_adr,
  output logic [DATA_W-1:0]   wb_dat,
  output logic [DATA_W/8-1:0] wb_sel,
  input  logic                wb_ack,
  output logic                sc_done,
  output logic                sc_pass,
  output logic                resv_valid
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [LINE_W-1:0] resv_line;
  logic              hit_now, hit_prev, kill, sc_end;

  resv_snoop_match #(.LINE_W(LINE_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_valid (snp_valid),
    .snp_line  (snp_addr[ADDR_W-1:OFF_W]),
    .resv_line (resv_line),
    .hit_now   (hit_now),
    .hit_prev  (hit_prev)
  );

  resv_tracker #(.LINE_W(LINE_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .lr_s0_valid   (lr_s0_valid),
    .lr_s0_idx     (lr_s0_idx),
    .lr_s0_way     (lr_s0_way),
    .lr_s1_valid   (lr_s1_valid),
    .lr_s1_line    (lr_s1_addr[ADDR_W-1:OFF_W]),
    .lr_data_valid (lr_data_valid),
    .snp_valid     (snp_valid),
    .snp_idx       (snp_idx),
    .snp_way       (snp_way),
    .hit_any       (hit_now || hit_prev),
    .sc_end        (sc_end),
    .resv_valid    (resv_valid),
    .resv_line     (resv_line),
    .kill          (kill)
  );

  sc_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_req     (sc_req),
    .sc_addr    (sc_addr),
    .sc_data    (sc_data),
    .sc_sel     (sc_sel),
    .resv_valid (resv_valid),
    .resv_line  (resv_line),
    .kill       (kill),
    .wb_ack     (wb_ack),
    .wb_cyc     (wb_cyc),
    .wb_stb     (wb_stb),
    .wb_we      (wb_we),
    .wb_adr     (wb_adr),
    .wb_dat     (wb_dat),
    .wb_sel     (wb_sel),
    .sc_done    (sc_done),
    .sc_pass    (sc_pass),
    .sc_end     (sc_end)
  );

  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n |-> !resv_valid && !wb_cyc && !sc_done);
endmodule

// File: tb/resv_sc_unit_bench.sv
module resv_sc_unit_bench;
  localparam int AW = 32, DW = 64, IW = 6, WW = 2, OFF = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic lr_s0_valid, lr_s1_valid, lr_data_valid, snp_valid, sc_req, wb_ack;
  logic [IW-1:0] lr_s0_idx, snp_idx;
  logic [WW-1:0] lr_s0_way, snp_way;
  logic [AW-1:0] lr_s1_addr, snp_addr, sc_addr, wb_adr;
  logic [DW-1:0] sc_data, wb_dat;
  logic [DW/8-1:0] sc_sel, wb_sel;
  logic wb_cyc, wb_stb, wb_we, sc_done, sc_pass, resv_valid;

  int n_run = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  resv_sc_unit u_resv_sc_unit (
    .clk(clk), .rst_n(rst_n),
    .lr_s0_valid(lr_s0_valid), .lr_s0_idx(lr_s0_idx), .lr_s0_way(lr_s0_way),
    .lr_s1_valid(lr_s1_valid), .lr_s1_addr(lr_s1_addr), .lr_data_valid(lr_data_valid),
    .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_way(snp_way), .snp_addr(snp_addr),
    .sc_req(sc_req), .sc_addr(sc_addr), .sc_data(sc_data), .sc_sel(sc_sel),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat(wb_dat), .wb_sel(wb_sel), .wb_ack(wb_ack),
    .sc_done(sc_done), .sc_pass(sc_pass), .resv_valid(resv_valid)
  );

  // behavioural reference state
  bit          m_valid, m_pend, m_s0kill, m_prev_v, m_busy, m_done, m_pass;
  int unsigned m_line, m_prev_line;
  logic [AW-1:0] m_adr;

  function automatic int unsigned line_of(logic [AW-1:0] a);
    return int'(a >> OFF);
  endfunction

  function automatic bit m_kill();
    bit hit;
    hit = (snp_valid && line_of(snp_addr) == m_line) ||
          (m_prev_v && m_prev_line == m_line);
    return (m_valid || m_pend) && hit;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_pend = 0; m_s0kill = 0; m_prev_v = 0;
      m_busy = 0; m_done = 0; m_pass = 0; m_line = 0; m_prev_line = 0;
    end else begin
      bit k, fin, ok;
      k = m_kill(); fin = 0; ok = 0;
      if (m_busy) begin
        if (k) fin = 1;
        else if (wb_ack) begin fin = 1; ok = 1; end
      end else if (sc_req) begin
        if (m_valid && !k && line_of(sc_addr) == m_line) begin
          m_busy = 1; m_adr = sc_addr;
        end else fin = 1;
      end
      if (fin) m_busy = 0;
      m_done = fin; m_pass = ok;
      if (lr_s1_valid) begin
        m_line = line_of(lr_s1_addr); m_valid = 0; m_pend = !m_s0kill;
      end else if (k || fin) begin
        m_valid = 0; m_pend = 0;
      end else if (lr_data_valid && m_pend) begin
        m_valid = 1; m_pend = 0;
      end
      m_s0kill = lr_s0_valid && snp_valid && snp_idx == lr_s0_idx && snp_way == lr_s0_way;
      m_prev_v = snp_valid;
      if (snp_valid) m_prev_line = line_of(snp_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // continuous comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      bit ecyc;
      ecyc = m_busy && !m_kill();
      chk(resv_valid == m_valid, "R4 resv_valid vs model", resv_valid, m_valid);
      chk(wb_cyc == ecyc && wb_stb == ecyc, "R10 cyc/stb vs model", wb_cyc, ecyc);
      chk(sc_done == m_done, "R8 sc_done vs model", sc_done, m_done);
      chk(!sc_done || sc_pass == m_pass, "R9 sc_pass vs model", sc_pass, m_pass);
      if (ecyc) chk(wb_adr == m_adr && wb_we, "R8 wb_adr vs model", wb_adr, m_adr);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    lr_s0_valid = 0; lr_s1_valid = 0; lr_data_valid = 0;
    snp_valid = 0; sc_req = 0; wb_ack = 0;
  endtask

  task automatic lr_front(input logic [AW-1:0] a, input int idx, input int way);
    lr_s0_valid = 1; lr_s0_idx = IW'(idx); lr_s0_way = WW'(way); step();
    lr_s1_valid = 1; lr_s1_addr = a; step();
  endtask

  task automatic snoop(input logic [AW-1:0] a, input int idx, input int way);
    snp_valid = 1; snp_addr = a; snp_idx = IW'(idx); snp_way = WW'(way);
  endtask

  task automatic look(input logic e, input logic a, input string req);
    @(negedge clk);
    chk(a == e, req, a, e);
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1240, B = 32'h0000_1280;

  initial begin
    rst_n = 0;
    lr_s0_valid = 0; lr_s1_valid = 0; lr_data_valid = 0; snp_valid = 0;
    sc_req = 0; wb_ack = 0; lr_s0_idx = 0; lr_s0_way = 0; lr_s1_addr = 0;
    snp_idx = 0; snp_way = 0; snp_addr = 0; sc_addr = 0; sc_data = 0; sc_sel = 0;
    repeat (3) @(negedge clk);
    chk(!resv_valid && !wb_cyc && !sc_done, "R1 reset state", {resv_valid, wb_cyc, sc_done}, 0);
    rst_n = 1; step();
    look(0, resv_valid, "R1 idle after reset");

    // R2 capture then validate on data
    lr_front(A, 9, 1);
    look(0, resv_valid, "R2 not valid before data");
    step(); lr_data_valid = 1; step();
    look(1, resv_valid, "R2 valid after data strobe");

    // R4 other line keeps, same line (offset inside) kills
    snoop(B, 3, 0); step();
    look(1, resv_valid, "R4 other line ignored");
    snoop(A + 32'h18, 9, 1); step();
    look(0, resv_valid, "R4 same line clears");

    // R8 successful store-conditional, R11 cleared afterwards
    lr_front(A, 9, 1); lr_data_valid = 1; step(); step(); step();
    sc_req = 1; sc_addr = A + 8; sc_data = 64'hDEAD_BEEF_0123_4567; sc_sel = 8'hF0; step();
    look(1, wb_cyc, "R8 cyc raised");
    chk(wb_adr == A + 8 && wb_dat == 64'hDEAD_BEEF_0123_4567 && wb_sel == 8'hF0,
        "R8 bus payload", wb_adr, A + 8);
    step(); wb_ack = 1; step();
    look(1, sc_done, "R8 done after ack");
    chk(sc_pass, "R8 pass", sc_pass, 1);
    chk(!resv_valid, "R11 cleared after pass", resv_valid, 0);

    // R9 no reservation, then wrong line
    sc_req = 1; sc_addr = A; step();
    look(0, wb_cyc, "R9 no bus when invalid");
    chk(sc_done && !sc_pass, "R9 fail without reservation", sc_pass, 0);
    lr_front(A, 9, 1); lr_data_valid = 1; step(); step();
    sc_req = 1; sc_addr = B; step();
    look(1, sc_done, "R9 done on line mismatch");
    chk(!sc_pass && !wb_cyc, "R9 fail on line mismatch", sc_pass, 0);
    chk(!resv_valid, "R11 cleared after fail", resv_valid, 0);

    // R5 stage-0 index/way hit
    lr_s0_valid = 1; lr_s0_idx = 12; lr_s0_way = 2; snoop(32'h0009_0000, 12, 2); step();
    lr_s1_valid = 1; lr_s1_addr = A; step();
    lr_data_valid = 1; step(); step();
    look(0, resv_valid, "R5 stage0 idx/way kill");

    // R6 stage-1 address hit
    lr_s0_valid = 1; lr_s0_idx = 9; lr_s0_way = 1; step();
    lr_s1_valid = 1; lr_s1_addr = A; snoop(A + 4, 0, 0); step();
    step(); lr_data_valid = 1; step();
    look(0, resv_valid, "R6 stage1 delayed kill");

    // R3 quad: second strobe must not revive
    lr_front(A, 9, 1); lr_data_valid = 1; step();
    look(1, resv_valid, "R3 first doubleword validates");
    snoop(A, 9, 1); step(); lr_data_valid = 1; step();
    look(0, resv_valid, "R3 second doubleword ignored");

    // R7 kill beats data strobe
    lr_front(A, 9, 1); step();
    lr_data_valid = 1; snoop(A + 60, 9, 1); step(); step();
    look(0, resv_valid, "R7 clear wins over set");

    // R10 abort on bus
    lr_front(B, 10, 3); lr_data_valid = 1; step(); step();
    sc_req = 1; sc_addr = B; sc_data = 64'h1; sc_sel = 8'h01; step();
    look(1, wb_cyc, "R10 bus started");
    step(); snoop(B + 2, 10, 3); #1;
    chk(!wb_cyc && !wb_stb, "R10 cyc dropped same cycle", wb_cyc, 0);
    step();
    look(1, sc_done, "R10 done after abort");
    chk(!sc_pass, "R10 abort fails", sc_pass, 1'b0);
    chk(!resv_valid, "R11 cleared after abort", resv_valid, 0);

    repeat (4) step();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule